// File: doc/BRIEF.md
# Byte-Pixel SPI Display Streamer

This block connects an 8-bit processor bus to a colour TFT panel over SPI. Software writes one byte per pixel, packed as 3 bits of red, 3 bits of green and 2 bits of blue. The block widens each byte to a 16-bit panel colour and places it in an internal FIFO. An SPI master empties that FIFO on its own, sending each pixel as two bytes at the full SPI rate. The processor deposits a run of pixels and returns to other work without polling between bytes.

Command bytes use a separate direct register and skip the colour widening. A full-duplex transfer register sends a byte and captures the byte returned by the panel. A status/control register reports the FIFO and SPI state, holds the SPI clock divider and clears a sticky overflow flag. A command or transfer is taken only when the FIFO is empty and the SPI master is idle, so a command can never overtake queued pixels.

Top module: `pix_spi_streamer`

## Requirements
- R1: A pixel byte p (red = p[7:5], green = p[4:2], blue = p[1:0]) is widened by bit replication: red5 = {r, r[2:1]}, green6 = {g, g}, blue5 = {b, b, b[1]}. The colour word is {red5, green6, blue5}. The high byte goes on the wire first, each byte MSB first. Examples: 0x00→0x0000, 0xFF→0xFFFF, 0x25→0x212A.
- R2: Pixels written to address 0 are queued and sent without further bus activity. Chip select stays low across both bytes of a pixel. Back-to-back queued bytes follow with no idle SCK period between them.
- R3: A pixel write while the FIFO is full is discarded and sets the sticky overflow flag (status bit 7). Writing address 3 with bit 7 = 1 clears the flag.
- R4: A write to address 1 sends that byte with DC low. It is taken only when the FIFO is empty and the SPI master is idle. Otherwise it is discarded and nothing reaches the wire.
- R5: A write to address 2 sends the byte with DC high, under the same idle condition as R4. The incoming MISO byte, sampled on rising SCK edges MSB first, is read back at address 2.
- R6: SPI mode 0. SCK is low while idle and MOSI changes only while SCK is low. The SCK period is 2^(k+1) system clocks, where k is written to address 3 bits [2:0].
- R7: DC stays stable for every whole byte on the wire. It is high for pixel and transfer bytes and low for command bytes.
- R8: Reading address 3 returns {overflow, busy, full, empty, 0, k[2:0]}. Every read returns its data on the cycle after the read strobe.
- R9: After reset, chip select is high, SCK is low, k = 0 and the status reads 0x10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Register write strobe |
| bus_re | input | 1 | Register read strobe |
| bus_addr | input | 2 | Register select: 0 pixel, 1 command, 2 transfer, 3 status/control |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, registered |
| spi_sck | output | 1 | SPI clock |
| spi_mosi | output | 1 | SPI data out |
| spi_miso | input | 1 | SPI data in |
| spi_cs_n | output | 1 | SPI chip select, active low |
| spi_dc | output | 1 | Data/command select, low for command bytes |

## Verification
The bench builds the block with FIFO_DEPTH = 8 and DIV_W = 3. The shallow FIFO fills after nine quick pixel writes, so the full flag, the dropped-pixel path, the overflow clear and the refused command can all be exercised in a few hundred cycles. The 3-bit divider exponent lets the bench set k to 0, 1, 2 and 3. That covers both the fastest SCK rate, where back-to-back bytes have no slack, and slow rates where the FIFO can be filled while a byte is still on the wire.

// File: rtl/pss_pkg.sv
package pss_pkg;
  typedef enum logic [1:0] {
    REG_PIXEL = 2'd0,
    REG_CMD   = 2'd1,
    REG_XFER  = 2'd2,
    REG_CTRL  = 2'd3
  } reg_sel_e;

  localparam int PIX_IN_W  = 8;
  localparam int PIX_OUT_W = 16;
endpackage

// File: rtl/pss_rgb_widen.sv
module pss_rgb_widen
  import pss_pkg::*;
(
  input  logic [PIX_IN_W-1:0]  pix_in,
  output logic [PIX_OUT_W-1:0] pix_out
);
  logic [2:0] red3, grn3;
  logic [1:0] blu2;

  assign red3 = pix_in[7:5];
  assign grn3 = pix_in[4:2];
  assign blu2 = pix_in[1:0];

  // replicate the top bits into the low end so zero and full scale stay exact
  assign pix_out = {red3, red3[2:1], grn3, grn3, blu2, blu2, blu2[1]};
endmodule

// File: rtl/pss_fifo.sv
module pss_fifo #(
  parameter int W     = 16,
  parameter int DEPTH = 16   // power of two
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic [W-1:0] wdata,
  input  logic         pop,
  output logic [W-1:0] rdata,
  output logic         empty,
  output logic         full
);
  localparam int AW = $clog2(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp, ra;
  logic [AW:0]   cnt;
  logic [W-1:0]  rq, bq;
  logic          byp;

  // look-ahead read address keeps the head word ready in a registered output
  assign ra    = rp + AW'(pop);
  assign empty = (cnt == '0);
  assign full  = (cnt == (AW+1)'(DEPTH));
  assign rdata = byp ? bq : rq;

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= wdata;
    rq <= mem[ra];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
      byp <= 1'b0;
      bq  <= '0;
    end else begin
      if (push) wp <= wp + AW'(1);
      rp  <= ra;
      cnt <= cnt + (AW+1)'(push) - (AW+1)'(pop);
      byp <= push && (wp == ra);
      bq  <= wdata;
    end
  end

  p_push_not_full_r3: assert property (@(posedge clk) disable iff (rst) push |-> !full)
    else $error("push into full FIFO");
  p_pop_not_empty_r2: assert property (@(posedge clk) disable iff (rst) pop |-> !empty)
    else $error("pop from empty FIFO");
endmodule

// File: rtl/pss_spi_master.sv
module pss_spi_master #(
  parameter int DIV_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DIV_W-1:0] div_exp,
  input  logic             one_go,
  input  logic [7:0]       one_byte,
  input  logic             one_dc,
  input  logic             fifo_empty,
  input  logic [15:0]      fifo_word,
  output logic             fifo_pop,
  output logic             busy,
  output logic [7:0]       rx_byte,
  output logic             sck,
  output logic             mosi,
  input  logic             miso,
  output logic             cs_n,
  output logic             dc
);
  localparam int CW = (1 << DIV_W);

  logic [CW-1:0] hcnt, lim;
  logic [7:0]    shr, sec, rxs;
  logic [2:0]    bitcnt;
  logic          has2, tick, last_edge;

  assign lim       = (CW'(1) << div_exp) - CW'(1);
  assign tick      = busy && (hcnt == lim);
  assign last_edge = tick && sck && (bitcnt == 3'd7);
  assign fifo_pop  = !fifo_empty && (!busy || (last_edge && !has2));

  always_ff @(posedge clk) begin
    if (rst) begin
      busy    <= 1'b0;
      sck     <= 1'b0;
      mosi    <= 1'b0;
      cs_n    <= 1'b1;
      dc      <= 1'b0;
      hcnt    <= '0;
      shr     <= '0;
      sec     <= '0;
      rxs     <= '0;
      rx_byte <= '0;
      bitcnt  <= '0;
      has2    <= 1'b0;
    end else if (!busy) begin
      hcnt   <= '0;
      bitcnt <= '0;
      sck    <= 1'b0;
      if (fifo_pop) begin
        busy <= 1'b1;
        cs_n <= 1'b0;
        dc   <= 1'b1;
        shr  <= fifo_word[15:8];
        mosi <= fifo_word[15];
        sec  <= fifo_word[7:0];
        has2 <= 1'b1;
      end else if (one_go) begin
        busy <= 1'b1;
        cs_n <= 1'b0;
        dc   <= one_dc;
        shr  <= one_byte;
        mosi <= one_byte[7];
        has2 <= 1'b0;
      end
    end else begin
      hcnt <= tick ? '0 : hcnt + CW'(1);
      if (tick) begin
        if (!sck) begin
          sck <= 1'b1;
          rxs <= {rxs[6:0], miso};
        end else begin
          sck <= 1'b0;
          if (bitcnt != 3'd7) begin
            bitcnt <= bitcnt + 3'd1;
            shr    <= {shr[6:0], 1'b0};
            mosi   <= shr[6];
          end else begin
            rx_byte <= rxs;
            bitcnt  <= '0;
            if (has2) begin
              shr  <= sec;
              mosi <= sec[7];
              has2 <= 1'b0;
            end else if (fifo_pop) begin
              dc   <= 1'b1;
              shr  <= fifo_word[15:8];
              mosi <= fifo_word[15];
              sec  <= fifo_word[7:0];
              has2 <= 1'b1;
            end else begin
              busy <= 1'b0;
              cs_n <= 1'b1;
            end
          end
        end
      end
    end
  end

  p_sck_idle_low_r6: assert property (@(posedge clk) disable iff (rst) cs_n |-> !sck)
    else $error("SCK high while deselected");
  p_mosi_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (sck && $past(sck)) |-> $stable(mosi))
    else $error("MOSI moved while SCK high");
  p_dc_stable_r7: assert property (@(posedge clk) disable iff (rst)
    (!cs_n && $past(!cs_n) && !$stable(dc)) |-> $fell(sck))
    else $error("DC moved inside a byte");
  p_pair_cs_r2: assert property (@(posedge clk) disable iff (rst)
    (busy && has2) |=> !cs_n)
    else $error("chip select released inside a pixel");
endmodule

// File: rtl/pix_spi_streamer.sv
module pix_spi_streamer
  import pss_pkg::*;
#(
  parameter int FIFO_DEPTH = 16,
  parameter int DIV_W      = 3   // 1..3, reported in status bits [2:0]
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       bus_we,
  input  logic       bus_re,
  input  logic [1:0] bus_addr,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  output logic       spi_sck,
  output logic       spi_mosi,
  input  logic       spi_miso,
  output logic       spi_cs_n,
  output logic       spi_dc
);
  reg_sel_e             sel;
  logic [PIX_OUT_W-1:0] wide, f_word;
  logic                 f_empty, f_full, f_pop, m_busy;
  logic                 pix_push, pix_drop, one_go, ovf_clr;
  logic                 ovf_q;
  logic [DIV_W-1:0]     div_q;
  logic [7:0]           rx_byte, status;
  logic                 wdata_unused;

  assign sel          = reg_sel_e'(bus_addr);
  assign pix_push     = bus_we && (sel == REG_PIXEL) && !f_full;
  assign pix_drop     = bus_we && (sel == REG_PIXEL) && f_full;
  assign one_go       = bus_we && ((sel == REG_CMD) || (sel == REG_XFER)) && f_empty && !m_busy;
  assign ovf_clr      = bus_we && (sel == REG_CTRL) && bus_wdata[7];
  assign status       = {ovf_q, m_busy, f_full, f_empty, 1'b0, 3'(div_q)};
  assign wdata_unused = ^bus_wdata[6:DIV_W];

  pss_rgb_widen u_widen (.pix_in(bus_wdata), .pix_out(wide));

  pss_fifo #(.W(PIX_OUT_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk(clk), .rst(rst), .push(pix_push), .wdata(wide), .pop(f_pop),
    .rdata(f_word), .empty(f_empty), .full(f_full));

  pss_spi_master #(.DIV_W(DIV_W)) u_spi (
    .clk(clk), .rst(rst), .div_exp(div_q),
    .one_go(one_go), .one_byte(bus_wdata), .one_dc(sel == REG_XFER),
    .fifo_empty(f_empty), .fifo_word(f_word), .fifo_pop(f_pop),
    .busy(m_busy), .rx_byte(rx_byte),
    .sck(spi_sck), .mosi(spi_mosi), .miso(spi_miso), .cs_n(spi_cs_n), .dc(spi_dc));

  always_ff @(posedge clk) begin
    if (rst) begin
      ovf_q     <= 1'b0;
      div_q     <= '0;
      bus_rdata <= '0;
    end else begin
      if (pix_drop)     ovf_q <= 1'b1;
      else if (ovf_clr) ovf_q <= 1'b0;
      if (bus_we && (sel == REG_CTRL)) div_q <= bus_wdata[DIV_W-1:0];
      if (bus_re) begin
        case (sel)
          REG_CTRL: bus_rdata <= status;
          REG_XFER: bus_rdata <= rx_byte;
          default:  bus_rdata <= '0;
        endcase
      end
    end
  end

  p_full_drop_r3: assert property (@(posedge clk) disable iff (rst) pix_drop |=> ovf_q)
    else $error("dropped pixel did not flag overflow");
  p_ovf_sticky_r3: assert property (@(posedge clk) disable iff (rst)
    (ovf_q && !ovf_clr) |=> ovf_q)
    else $error("overflow flag cleared on its own");
  p_cmd_accept_r4: assert property (@(posedge clk) disable iff (rst) one_go |=> m_busy)
    else $error("direct byte not taken by SPI master");
endmodule

// File: tb/sim_pix_spi_streamer.sv
module sim_pix_spi_streamer;
  localparam int DEPTH = 8;
  localparam int DW    = 3;

  logic clk = 1'b0, rst = 1'b1, we = 1'b0, re = 1'b0;
  logic [1:0] addr = '0;
  logic [7:0] wdata = '0, rdata;
  logic sck, mosi, miso, cs_n, dc;

  always #2 clk = ~clk;

  pix_spi_streamer #(.FIFO_DEPTH(DEPTH), .DIV_W(DW)) u0 (
    .clk(clk), .rst(rst), .bus_we(we), .bus_re(re), .bus_addr(addr),
    .bus_wdata(wdata), .bus_rdata(rdata), .spi_sck(sck), .spi_mosi(mosi),
    .spi_miso(miso), .spi_cs_n(cs_n), .spi_dc(dc));

  int checks = 0, fails = 0, cyc = 0, period = 2, gap_err = 0, prev = 0;
  bit have_prev = 0, timed_out = 0;
  logic [8:0] exp_q[$];
  logic [7:0] msh = '0, slv = 8'hA5;
  logic [3:0] mbits = '0;

  always @(negedge clk) cyc++;

  // panel model: presents slv MSB first, one bit per SCK
  assign miso = slv[3'd7 - mbits[2:0]];

  // monitor: rebuild bytes from the pins and score them against the queue
  always @(posedge sck or posedge cs_n) begin
    if (cs_n) begin
      have_prev = 0;
      mbits = '0;
    end else begin
      if (have_prev && (cyc - prev) != period) gap_err++;
      prev = cyc;
      have_prev = 1;
      msh = {msh[6:0], mosi};
      mbits = mbits + 4'd1;
      if (mbits == 4'd8) begin
        mbits = '0;
        checks++;
        if (exp_q.size() == 0) begin
          fails++;
          $display("FAIL R2 R4 R7 unexpected byte act=%0h exp=none", {dc, msh});
        end else begin
          logic [8:0] e;
          e = exp_q.pop_front();
          if (e !== {dc, msh}) begin
            fails++;
            $display("FAIL R1 R7 wire byte act=%0h exp=%0h", {dc, msh}, e);
          end
        end
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); re = 1'b1; addr = a;
    @(negedge clk); re = 1'b0; d = rdata;
  endtask

  function automatic logic [15:0] widen(input logic [7:0] p);
    int r, g, b;
    r = p[7:5]; g = p[4:2]; b = p[1:0];
    return 16'((((r << 2) | (r >> 1)) << 11) | (((g << 3) | g) << 5) |
               ((b << 3) | (b << 1) | (b >> 1)));
  endfunction

  task automatic pix(input logic [7:0] p, input bit expect_sent);
    logic [15:0] w;
    w = widen(p);
    if (expect_sent) begin
      exp_q.push_back({1'b1, w[15:8]});
      exp_q.push_back({1'b1, w[7:0]});
    end
    wr(2'd0, p);
  endtask

  task automatic set_k(input int k);
    wr(2'd3, 8'(k));
    period = 2 << k;
  endtask

  task automatic wait_idle();
    logic [7:0] s;
    for (int i = 0; i < 20000; i++) begin
      rd(2'd3, s);
      if (!s[6] && s[4]) break;
    end
    repeat (4) @(negedge clk);
  endtask

  task automatic run();
    logic [7:0] s;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R9 cs_n after reset", cs_n, 1);
    chk("R9 sck after reset", sck, 0);
    rd(2'd3, s);
    chk("R9 R8 status after reset", s, 8'h10);

    // fastest rate, colour corners streamed back to back
    pix(8'h00, 1); pix(8'hFF, 1); pix(8'hE0, 1);
    pix(8'h1C, 1); pix(8'h03, 1); pix(8'h25, 1);
    chk("R1 widen 0x25", widen(8'h25), 16'h212A);
    chk("R1 widen 0xFF", widen(8'hFF), 16'hFFFF);
    wait_idle();
    chk("R2 all pixel bytes sent", exp_q.size(), 0);
    chk("R2 R6 no gaps at k=0", gap_err, 0);

    // command refused while pixels queued, accepted when idle
    pix(8'h4A, 1); pix(8'hB5, 1);
    wr(2'd1, 8'h2C);
    wait_idle();
    exp_q.push_back({1'b0, 8'h2A});
    wr(2'd1, 8'h2A);
    wait_idle();
    chk("R4 command path", exp_q.size(), 0);

    // divider k=2
    set_k(2);
    rd(2'd3, s);
    chk("R8 R6 status k=2", s, 8'h12);
    pix(8'h6D, 1); pix(8'h92, 1);
    wait_idle();
    chk("R6 period at k=2", gap_err, 0);

    // fill, overflow, clear
    set_k(3);
    for (int i = 0; i < DEPTH + 1; i++) pix(8'(i * 29 + 7), 1);
    rd(2'd3, s);
    chk("R3 R8 full flag", s, 8'h63);
    wr(2'd1, 8'h77);
    pix(8'hC0, 0); pix(8'h0F, 0);
    rd(2'd3, s);
    chk("R3 overflow set", s, 8'hE3);
    wr(2'd3, 8'h83);
    rd(2'd3, s);
    chk("R3 overflow cleared", s, 8'h63);
    wait_idle();
    chk("R3 R4 dropped writes never sent", exp_q.size(), 0);

    // full-duplex transfers
    set_k(1);
    slv = 8'hA5;
    exp_q.push_back({1'b1, 8'h3C});
    wr(2'd2, 8'h3C);
    wait_idle();
    rd(2'd2, s);
    chk("R5 received byte 1", s, 8'hA5);
    slv = 8'h5A;
    exp_q.push_back({1'b1, 8'hC3});
    wr(2'd2, 8'hC3);
    wait_idle();
    rd(2'd2, s);
    chk("R5 received byte 2", s, 8'h5A);
    chk("R5 R7 transfer bytes", exp_q.size(), 0);
    chk("R6 sck idle low", sck, 0);
    chk("R6 gaps overall", gap_err, 0);
  endtask

  initial begin
    fork
      run();
      begin
        repeat (150000) @(posedge clk);
        timed_out = 1;
      end
    join_any
    disable fork;
    if (timed_out) begin
      checks++;
      fails++;
      $display("FAIL watchdog act=timeout exp=finish");
    end
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end
endmodule